// File: doc/BRIEF.md
# Narrow-to-Wide Memory Access Bridge

This block sits between a simple 16-bit request port, in the style of an asynchronous static RAM, and the native user interface of a wide memory controller that moves 128-bit lines. Every narrow request, whether a read or a write, turns into exactly one line transaction. The line address is the request address with its low four bits forced to zero. The three address bits above the byte bit pick one of eight 16-bit lanes within that line.

A write copies the 16-bit word into every lane of the outgoing line. The byte mask then leaves open only the enabled bytes of the chosen lane. A read pulls the chosen lane out of the returned line. When just one byte enable is set, that byte appears in both halves of the result. One enumerated state machine sequences the transfer. Its states are CALWAIT (waiting for the controller to report calibration), IDLE (ready for a request), WRITE (write command and write data outstanding), RD_CMD (read command outstanding) and RD_WAIT (waiting for read data). Its transitions are:
- CALWAIT→IDLE when calibration completes.
- IDLE→WRITE when a write request is taken.
- IDLE→RD_CMD when a read request is taken.
- WRITE→IDLE once both the write command and the write data have been taken.
- RD_CMD→RD_WAIT when the read command is taken.
- RD_WAIT→IDLE when read data is captured.

Top module: `narrow_line_bridge`

## Requirements
- R1: After reset, `busy_o` is high and no command is issued until `cal_done_i` has been seen high. One clock edge later the bridge is idle, with `busy_o` low. Requests made before that are ignored.
- R2: `mc_addr_o` equals request address bits 26:4 followed by four zero bits. `mc_cmd_o` is 3'b000 for a write and 3'b001 for a read.
- R3: On a write, `mc_wdata_o` holds eight copies of the 16-bit word. The lane is L = address bits 3:1. Mask bit 2L (data bits 16L+7:16L) is the inverse of the lower-byte enable, mask bit 2L+1 is the inverse of the upper-byte enable, and every other mask bit is 1. A mask bit of 1 blocks that byte.
- R4: On a read, `rdata_o` takes lane L of `mc_rdata_i`. With only the upper enable set, it is {upper byte, upper byte}. With only the lower enable set, it is {lower byte, lower byte}. With both or neither set, it is the lane's full 16 bits.
- R5: `mc_en_o` stays high until a cycle with `mc_rdy_i` high. On a write, `mc_wren_o` and `mc_wend_o` stay high together until a cycle with `mc_wdf_rdy_i` high.
- R6: A write completes once both the command and the data have been taken, in either order or in the same cycle. `busy_o` falls at the edge where the second of the two is taken.
- R7: `busy_o` rises at the edge where a request is taken. While it is high, `req_i` is ignored. While it is low, neither `mc_en_o` nor `mc_wren_o` is high.
- R8: Address, byte enables, direction and write word are registered when a request is taken. Later changes on the request port leave the transaction in flight unchanged.
- R9: `mc_rvalid_i` is used only in RD_WAIT. At any other time it leaves `rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done_i | input | 1 | Controller calibration complete |
| req_i | input | 1 | Request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 27 | Request byte address |
| req_hi_en_i | input | 1 | Upper byte enable |
| req_lo_en_i | input | 1 | Lower byte enable |
| req_wdata_i | input | 16 | Write word |
| busy_o | output | 1 | Transaction in flight or calibration pending |
| rdata_o | output | 16 | Last captured read word |
| mc_addr_o | output | 27 | Line address to controller |
| mc_cmd_o | output | 3 | Command code |
| mc_en_o | output | 1 | Command valid |
| mc_rdy_i | input | 1 | Controller accepts command |
| mc_wdata_o | output | 128 | Write line |
| mc_wmask_o | output | 16 | Byte mask, 1 blocks a byte |
| mc_wren_o | output | 1 | Write data valid |
| mc_wend_o | output | 1 | Last beat of write data |
| mc_wdf_rdy_i | input | 1 | Controller accepts write data |
| mc_rdata_i | input | 128 | Read line |
| mc_rvalid_i | input | 1 | Read line valid |

## Verification
On a write, command acceptance and write-data acceptance can land on the same clock edge. They can also land on different edges, in either order. The bench raises `mc_rdy_i` and `mc_wdf_rdy_i` together in one case, command first in another, and data first in a third. In each case it judges whether the withdrawn handshake stays low, whether the other stays high, and whether `busy_o` falls exactly at the edge where the later of the two is taken. A stray `mc_rvalid_i` during the read command phase, and another while idle, check that read data is captured only in RD_WAIT.

// File: rtl/nlb_pkg.sv
package nlb_pkg;

    typedef enum logic [2:0] {
        ST_CALWAIT,
        ST_IDLE,
        ST_WRITE,
        ST_RD_CMD,
        ST_RD_WAIT
    } nlb_state_e;

    localparam logic [2:0] CMD_WRITE = 3'b000;
    localparam logic [2:0] CMD_READ  = 3'b001;

endpackage

// File: rtl/nlb_lane_pack.sv
module nlb_lane_pack #(
    parameter int WORD_W = 16,
    parameter int LINE_W = 128,
    localparam int LANES  = LINE_W / WORD_W,
    localparam int SEL_W  = $clog2(LANES),
    localparam int MASK_W = LINE_W / 8
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SEL_W-1:0]  lane_i,
    input  logic              hi_en_i,
    input  logic              lo_en_i,
    output logic [LINE_W-1:0] line_o,
    output logic [MASK_W-1:0] mask_o
);
    // Each lane carries the same word; only the selected lane is unmasked.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic hit;
        assign hit = (lane_i == SEL_W'(k));
        assign line_o[k*WORD_W +: WORD_W] = word_i;
        assign mask_o[2*k]     = !(hit && lo_en_i);
        assign mask_o[2*k + 1] = !(hit && hi_en_i);
    end
endmodule

// File: rtl/nlb_lane_pick.sv
module nlb_lane_pick #(
    parameter int WORD_W = 16,
    parameter int LINE_W = 128,
    localparam int LANES = LINE_W / WORD_W,
    localparam int SEL_W = $clog2(LANES),
    localparam int HALF  = WORD_W / 2
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [SEL_W-1:0]  lane_i,
    input  logic              hi_en_i,
    input  logic              lo_en_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] lane_word;
    logic [HALF-1:0]   upper;
    logic [HALF-1:0]   lower;

    always_comb begin
        lane_word = '0;
        for (int k = 0; k < LANES; k++) begin
            if (lane_i == SEL_W'(k)) begin
                lane_word = line_i[k*WORD_W +: WORD_W];
            end
        end
    end

    assign upper = lane_word[WORD_W-1:HALF];
    assign lower = lane_word[HALF-1:0];

    always_comb begin
        unique case ({hi_en_i, lo_en_i})
            2'b10:   word_o = {upper, upper};
            2'b01:   word_o = {lower, lower};
            default: word_o = lane_word;
        endcase
    end
endmodule

// File: rtl/nlb_fsm.sv
module nlb_fsm
    import nlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cal_done_i,
    input  logic       req_i,
    input  logic       req_we_i,
    input  logic       mc_rdy_i,
    input  logic       mc_wdf_rdy_i,
    input  logic       mc_rvalid_i,
    output logic       accept_o,
    output logic       capture_o,
    output logic       busy_o,
    output logic       mc_en_o,
    output logic [2:0] mc_cmd_o,
    output logic       mc_wren_o,
    output logic       mc_wend_o
);
    nlb_state_e state_q, state_d;
    logic       cmd_ok_q, cmd_ok_d;
    logic       dat_ok_q, dat_ok_d;
    logic       cmd_fire, dat_fire;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_CALWAIT;
            cmd_ok_q <= 1'b0;
            dat_ok_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cmd_ok_q <= cmd_ok_d;
            dat_ok_q <= dat_ok_d;
        end
    end

    assign cmd_fire = mc_en_o && mc_rdy_i;
    assign dat_fire = mc_wren_o && mc_wdf_rdy_i;

    // Transitions
    always_comb begin
        state_d  = state_q;
        cmd_ok_d = cmd_ok_q;
        dat_ok_d = dat_ok_q;
        unique case (state_q)
            ST_CALWAIT: begin
                if (cal_done_i) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                cmd_ok_d = 1'b0;
                dat_ok_d = 1'b0;
                if (req_i) state_d = req_we_i ? ST_WRITE : ST_RD_CMD;
            end
            ST_WRITE: begin
                if (cmd_fire) cmd_ok_d = 1'b1;
                if (dat_fire) dat_ok_d = 1'b1;
                if ((cmd_ok_q || cmd_fire) && (dat_ok_q || dat_fire)) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_CMD: begin
                if (cmd_fire) state_d = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mc_rvalid_i) state_d = ST_IDLE;
            end
            default: state_d = ST_CALWAIT;
        endcase
    end

    // Outputs
    always_comb begin
        accept_o  = 1'b0;
        capture_o = 1'b0;
        busy_o    = 1'b1;
        mc_en_o   = 1'b0;
        mc_cmd_o  = CMD_WRITE;
        mc_wren_o = 1'b0;
        mc_wend_o = 1'b0;
        unique case (state_q)
            ST_CALWAIT: begin
                busy_o = 1'b1;
            end
            ST_IDLE: begin
                busy_o   = 1'b0;
                accept_o = req_i;
            end
            ST_WRITE: begin
                mc_cmd_o  = CMD_WRITE;
                mc_en_o   = !cmd_ok_q;
                mc_wren_o = !dat_ok_q;
                mc_wend_o = !dat_ok_q;
            end
            ST_RD_CMD: begin
                mc_cmd_o = CMD_READ;
                mc_en_o  = 1'b1;
            end
            ST_RD_WAIT: begin
                mc_cmd_o  = CMD_READ;
                capture_o = mc_rvalid_i;
            end
            default: busy_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/narrow_line_bridge.sv
module narrow_line_bridge #(
    parameter int ADDR_W = 27,
    parameter int WORD_W = 16,
    parameter int LINE_W = 128,
    localparam int LANES  = LINE_W / WORD_W,
    localparam int SEL_W  = $clog2(LANES),
    localparam int MASK_W = LINE_W / 8,
    localparam int OFS_W  = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_done_i,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_hi_en_i,
    input  logic              req_lo_en_i,
    input  logic [WORD_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic [WORD_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mc_addr_o,
    output logic [2:0]        mc_cmd_o,
    output logic              mc_en_o,
    input  logic              mc_rdy_i,
    output logic [LINE_W-1:0] mc_wdata_o,
    output logic [MASK_W-1:0] mc_wmask_o,
    output logic              mc_wren_o,
    output logic              mc_wend_o,
    input  logic              mc_wdf_rdy_i,
    input  logic [LINE_W-1:0] mc_rdata_i,
    input  logic              mc_rvalid_i
);
    logic              accept, capture;
    logic [ADDR_W-1:0] addr_q;
    logic              hi_q, lo_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_q;
    logic [WORD_W-1:0] picked;
    logic [SEL_W-1:0]  lane;
    logic              unused_byte_bit;

    nlb_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cal_done_i   (cal_done_i),
        .req_i        (req_i),
        .req_we_i     (req_we_i),
        .mc_rdy_i     (mc_rdy_i),
        .mc_wdf_rdy_i (mc_wdf_rdy_i),
        .mc_rvalid_i  (mc_rvalid_i),
        .accept_o     (accept),
        .capture_o    (capture),
        .busy_o       (busy_o),
        .mc_en_o      (mc_en_o),
        .mc_cmd_o     (mc_cmd_o),
        .mc_wren_o    (mc_wren_o),
        .mc_wend_o    (mc_wend_o)
    );

    // Request capture: fields frozen for the whole transaction.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            hi_q    <= 1'b0;
            lo_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr_i;
            hi_q    <= req_hi_en_i;
            lo_q    <= req_lo_en_i;
            wdata_q <= req_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= picked;
        end
    end

    assign lane            = addr_q[OFS_W-1:1];
    assign unused_byte_bit = addr_q[0];
    assign mc_addr_o       = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign rdata_o         = rdata_q;

    nlb_lane_pack #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_pack (
        .word_i  (wdata_q),
        .lane_i  (lane),
        .hi_en_i (hi_q),
        .lo_en_i (lo_q),
        .line_o  (mc_wdata_o),
        .mask_o  (mc_wmask_o)
    );

    nlb_lane_pick #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_pick (
        .line_i  (mc_rdata_i),
        .lane_i  (lane),
        .hi_en_i (hi_q),
        .lo_en_i (lo_q),
        .word_o  (picked)
    );
endmodule

// File: rtl/nlb_checker.sv
module nlb_checker #(
    parameter int ADDR_W = 27,
    parameter int WORD_W = 16,
    parameter int LINE_W = 128,
    localparam int MASK_W = LINE_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic [WORD_W-1:0] rdata_o,
    input logic [ADDR_W-1:0] mc_addr_o,
    input logic [2:0]        mc_cmd_o,
    input logic              mc_en_o,
    input logic              mc_rdy_i,
    input logic [LINE_W-1:0] mc_wdata_o,
    input logic [MASK_W-1:0] mc_wmask_o,
    input logic              mc_wren_o,
    input logic              mc_wdf_rdy_i
);
    // R5: a stalled command is held with its address and code
    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        mc_en_o && !mc_rdy_i |=> mc_en_o && $stable(mc_addr_o) && $stable(mc_cmd_o));

    // R8: stalled write data keeps its line and mask
    assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        mc_wren_o && !mc_wdf_rdy_i |=> mc_wren_o && $stable(mc_wdata_o) && $stable(mc_wmask_o));

    // R3: at most one lane (two bytes) is ever open
    assert_mask_lane_R3: assert property (@(posedge clk) disable iff (rst)
        mc_wren_o |-> $countones(mc_wmask_o) >= MASK_W - 2);

    // R7: idle bridge drives no handshake
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mc_en_o && !mc_wren_o);

    // R9: read word only changes while a transaction is in flight
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |=> $stable(rdata_o));
endmodule

bind narrow_line_bridge nlb_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .LINE_W (LINE_W)
) u_nlb_checker (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .rdata_o      (rdata_o),
    .mc_addr_o    (mc_addr_o),
    .mc_cmd_o     (mc_cmd_o),
    .mc_en_o      (mc_en_o),
    .mc_rdy_i     (mc_rdy_i),
    .mc_wdata_o   (mc_wdata_o),
    .mc_wmask_o   (mc_wmask_o),
    .mc_wren_o    (mc_wren_o),
    .mc_wdf_rdy_i (mc_wdf_rdy_i)
);

// File: tb/test_narrow_line_bridge.sv
module test_narrow_line_bridge;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cal = 1'b0;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [26:0]  addr = '0;
    logic         hi = 1'b0;
    logic         lo = 1'b0;
    logic [15:0]  wd = '0;
    logic         busy;
    logic [15:0]  rdata;
    logic [26:0]  mc_addr;
    logic [2:0]   mc_cmd;
    logic         mc_en;
    logic         mc_rdy = 1'b0;
    logic [127:0] mc_wdata;
    logic [15:0]  mc_wmask;
    logic         mc_wren;
    logic         mc_wend;
    logic         mc_wrdy = 1'b0;
    logic [127:0] mc_rline = '0;
    logic         mc_rvalid = 1'b0;

    int total = 0;
    int bad = 0;
    logic [15:0] last_rd = '0;

    always #5 clk = ~clk;

    narrow_line_bridge i_narrow_line_bridge (
        .clk(clk), .rst(rst), .cal_done_i(cal),
        .req_i(req), .req_we_i(we), .req_addr_i(addr),
        .req_hi_en_i(hi), .req_lo_en_i(lo), .req_wdata_i(wd),
        .busy_o(busy), .rdata_o(rdata),
        .mc_addr_o(mc_addr), .mc_cmd_o(mc_cmd), .mc_en_o(mc_en), .mc_rdy_i(mc_rdy),
        .mc_wdata_o(mc_wdata), .mc_wmask_o(mc_wmask), .mc_wren_o(mc_wren),
        .mc_wend_o(mc_wend), .mc_wdf_rdy_i(mc_wrdy),
        .mc_rdata_i(mc_rline), .mc_rvalid_i(mc_rvalid)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] test_line();
        logic [127:0] l;
        for (int k = 0; k < 8; k++) l[k*16 +: 16] = {8'h90 + 8'(k), 8'h20 + 8'(k)};
        return l;
    endfunction

    task automatic issue(input logic w, input logic [26:0] a, input logic h,
                         input logic l, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; hi = h; lo = l; wd = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset_cal();
        chk("R1 busy in reset", 128'(busy), 128'(1));
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 busy before cal", 128'(busy), 128'(1));
        issue(1'b0, 27'h100, 1'b1, 1'b1, 16'h0);
        repeat (2) @(negedge clk);
        chk("R1 no command before cal", 128'(mc_en), 128'(0));
        cal = 1'b1;
        @(negedge clk);
        chk("R1 idle after cal", 128'(busy), 128'(0));
        chk("R1 early request dropped", 128'(mc_en), 128'(0));
    endtask

    task automatic t_write_same_cycle();
        issue(1'b1, 27'h1234, 1'b1, 1'b1, 16'hBEEF);
        chk("R2 write addr", 128'(mc_addr), 128'(27'h1230));
        chk("R2 write cmd", 128'(mc_cmd), 128'(3'b000));
        chk("R7 busy after accept", 128'(busy), 128'(1));
        chk("R5 en/wren/wend", 128'({mc_en, mc_wren, mc_wend}), 128'(3'b111));
        chk("R3 replicated line", mc_wdata, {8{16'hBEEF}});
        chk("R3 mask lane2 both", 128'(mc_wmask), 128'(16'hFFCF));
        mc_rdy = 1'b1; mc_wrdy = 1'b1;
        @(negedge clk);
        mc_rdy = 1'b0; mc_wrdy = 1'b0;
        chk("R6 same-cycle completion", 128'(busy), 128'(0));
        chk("R7 idle quiet", 128'({mc_en, mc_wren}), 128'(0));
    endtask

    task automatic t_write_cmd_first();
        issue(1'b1, 27'h7ABCDE, 1'b1, 1'b0, 16'h1357);
        chk("R2 addr lane7", 128'(mc_addr), 128'(27'h7ABCD0));
        chk("R3 mask lane7 upper", 128'(mc_wmask), 128'(16'h7FFF));
        mc_rdy = 1'b1;
        @(negedge clk);
        mc_rdy = 1'b0;
        chk("R5 en dropped after take", 128'(mc_en), 128'(0));
        chk("R5 wren held", 128'({mc_wren, mc_wend}), 128'(2'b11));
        chk("R6 busy until data", 128'(busy), 128'(1));
        req = 1'b1; we = 1'b0; addr = 27'h0; hi = 1'b0; lo = 1'b1; wd = 16'h0;
        @(negedge clk);
        req = 1'b0;
        chk("R8 line kept", mc_wdata, {8{16'h1357}});
        chk("R8 mask kept", 128'(mc_wmask), 128'(16'h7FFF));
        chk("R8 addr kept", 128'(mc_addr), 128'(27'h7ABCD0));
        mc_wrdy = 1'b1;
        @(negedge clk);
        mc_wrdy = 1'b0;
        chk("R6 done after data", 128'(busy), 128'(0));
        @(negedge clk);
        chk("R7 request while busy ignored", 128'({busy, mc_en}), 128'(0));
    endtask

    task automatic t_write_data_first();
        issue(1'b1, 27'h40, 1'b0, 1'b1, 16'hA55A);
        chk("R3 mask lane0 lower", 128'(mc_wmask), 128'(16'hFFFE));
        mc_wrdy = 1'b1;
        @(negedge clk);
        mc_wrdy = 1'b0;
        chk("R5 wren dropped, en held", 128'({mc_wren, mc_en}), 128'(2'b01));
        chk("R6 busy until command", 128'(busy), 128'(1));
        mc_rdy = 1'b1;
        @(negedge clk);
        mc_rdy = 1'b0;
        chk("R6 done after command", 128'(busy), 128'(0));
    endtask

    task automatic t_read(input logic [26:0] a, input logic h, input logic l);
        logic [127:0] line;
        logic [2:0]   ln;
        logic [7:0]   ub, lb;
        logic [15:0]  exp;
        line = test_line();
        ln = a[3:1];
        ub = line[ln*16 + 8 +: 8];
        lb = line[ln*16 +: 8];
        case ({h, l})
            2'b10:   exp = {ub, ub};
            2'b01:   exp = {lb, lb};
            default: exp = {ub, lb};
        endcase
        issue(1'b0, a, h, l, 16'hFFFF);
        chk("R2 read cmd", 128'(mc_cmd), 128'(3'b001));
        chk("R2 read addr", 128'(mc_addr), 128'({a[26:4], 4'b0}));
        chk("R5 read en, no wren", 128'({mc_en, mc_wren}), 128'(2'b10));
        mc_rvalid = 1'b1; mc_rline = '1;
        @(negedge clk);
        mc_rvalid = 1'b0;
        chk("R9 valid during command ignored", 128'(rdata), 128'(last_rd));
        mc_rdy = 1'b1;
        @(negedge clk);
        mc_rdy = 1'b0;
        chk("R5 en dropped after read take", 128'(mc_en), 128'(0));
        repeat (2) @(negedge clk);
        chk("R7 busy awaiting data", 128'(busy), 128'(1));
        mc_rvalid = 1'b1; mc_rline = line;
        @(negedge clk);
        mc_rvalid = 1'b0;
        chk("R4 read lane word", 128'(rdata), 128'(exp));
        chk("R4 busy cleared after capture", 128'(busy), 128'(0));
        last_rd = exp;
        mc_rvalid = 1'b1; mc_rline = ~line;
        @(negedge clk);
        mc_rvalid = 1'b0;
        chk("R9 valid while idle ignored", 128'(rdata), 128'(last_rd));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_cal();
        t_write_same_cycle();
        t_write_cmd_first();
        t_write_data_first();
        t_read(27'h16, 1'b1, 1'b1);   // R4 both, lane 3
        t_read(27'h3A, 1'b1, 1'b0);   // R4 upper only, lane 5
        t_read(27'h0C, 1'b0, 1'b1);   // R4 lower only, lane 6
        t_read(27'h02, 1'b0, 1'b0);   // R4 neither, lane 1
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule